// File: doc/BRIEF.md
# Completion Ring Posting Engine

This block keeps one circular completion ring held in local memory. A producer hands it finished-command records, each carrying a command tag, a status code, the ID of the submission queue it came from, and that queue's current head pointer. The engine packs each record into a 128-bit entry, writes it into the slot the tail points at, and then steps the tail. The host drains entries and reports its progress by writing the head index.

Every entry carries a phase bit. The bit is 1 after the ring is set up and inverts each time the tail passes the last slot. The host can therefore tell fresh entries from stale ones without reading the tail. The engine also reports full and empty, blocks new records while the ring is full, rejects head writes that fall outside the ring, and can give a one-cycle interrupt strobe for each posting.

Top module: `cqp_engine`

## Requirements
- R1: After reset the ring is inactive. `req_ready`, `ring_full`, `irq_pulse` and `db_err` are 0, and `ring_empty` is 1.
- R2: A cycle with `cfg_load` high activates the ring. It sets the slot count to `cfg_qsize`+1, head and tail to 0 and phase to 1, clears `db_err`, and latches `cfg_irq_en`.
- R3: A posted entry on `ent_data` has this layout. Bits 31:0 hold the result. Bits 63:32 are zero. Bits 95:80 hold the submission queue ID and bits 79:64 the submission head. Bits 127:113 hold the status, bit 112 the current phase, and bits 111:96 the command tag.
- R4: A request is accepted in a cycle where both `req_valid` and `req_ready` are high. In that cycle `ent_we` is high and `ent_slot` equals the tail. At the next edge the tail moves to the following slot, and from slot `cfg_qsize` it moves back to 0.
- R5: The phase inverts at each wrap of the tail from the last slot to slot 0, and keeps its value otherwise.
- R6: `ring_full` is high when (tail+1) modulo the slot count equals the head. While it is high, `req_ready` is low, and a waiting request writes nothing and leaves the tail unchanged.
- R7: `ring_empty` is high exactly when the tail equals the head.
- R8: A head write (`db_valid`) with `db_head` no greater than `cfg_qsize` moves the head to `db_head`, which frees slots.
- R9: A head write with `db_head` greater than `cfg_qsize` leaves the head unchanged and sets `db_err`. `db_err` stays set until the next reset or `cfg_load`.
- R10: With interrupts enabled, `irq_pulse` is high for exactly the one cycle after each accepting cycle. With interrupts disabled it stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 1 | Set up (or re-set up) the ring |
| cfg_qsize | input | SLOT_AW | Zero-based slot count |
| cfg_irq_en | input | 1 | Interrupt enable, latched on cfg_load |
| req_valid | input | 1 | Completion record offered |
| req_ready | output | 1 | Record can be accepted this cycle |
| req_result | input | 32 | Command-specific result |
| req_status | input | 15 | Status code |
| req_sqid | input | 16 | Source submission queue ID |
| req_sqhd | input | 16 | Source submission head pointer |
| req_cid | input | 16 | Command tag |
| db_valid | input | 1 | Host head write strobe |
| db_head | input | SLOT_AW | New head index |
| ent_we | output | 1 | Entry write strobe |
| ent_slot | output | SLOT_AW | Slot being written |
| ent_data | output | 128 | Packed entry |
| ring_full | output | 1 | No free slot |
| ring_empty | output | 1 | No unconsumed entry |
| ring_phase | output | 1 | Current phase value |
| ring_tail | output | SLOT_AW | Current tail index |
| db_err | output | 1 | Sticky bad head write flag |
| irq_pulse | output | 1 | Interrupt strobe |

## Verification
The hardest states to reach from the ports are a wrap that flips the phase while the head sits partway round the ring, and a rejected head write. The rejected write has to be told apart from a good one by what it fails to change. The bench fills a four-slot ring until it is full and frees two slots with a head write. It then posts across the wrap, so that the entry written into slot 0 must carry phase 0. With the ring full again, it writes an out-of-range head. The block must still report full, which shows the head did not move, while the error flag rises and stays set through a later legal head write.

// File: rtl/cqp_pkg.sv
package cqp_pkg;

    typedef struct packed {
        logic [31:0] dw3;
        logic [31:0] dw2;
        logic [31:0] dw1;
        logic [31:0] dw0;
    } cq_entry_t;

    localparam int ENTRY_BITS = $bits(cq_entry_t);

    function automatic cq_entry_t pack_entry(
        input logic [31:0] result,
        input logic [14:0] status,
        input logic        phase,
        input logic [15:0] sqid,
        input logic [15:0] sqhd,
        input logic [15:0] cid
    );
        cq_entry_t e;
        e.dw0 = result;
        e.dw1 = '0;
        e.dw2 = {sqid, sqhd};
        e.dw3 = {status, phase, cid};
        return e;
    endfunction

endpackage

// File: rtl/cqp_ring_ptrs.sv
module cqp_ring_ptrs #(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_load,
    input  logic [AW-1:0] cfg_last,
    input  logic          push,
    input  logic          db_valid,
    input  logic [AW-1:0] db_head,
    output logic          active,
    output logic [AW-1:0] last,
    output logic [AW-1:0] tail,
    output logic [AW-1:0] head,
    output logic          phase,
    output logic          err,
    output logic          full,
    output logic          empty
);
    logic [AW-1:0] nxt_tail;
    logic          at_last;

    assign at_last  = (tail == last);
    assign nxt_tail = at_last ? '0 : tail + 1'b1;
    assign full     = active && (nxt_tail == head);
    assign empty    = (tail == head);

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            last   <= '0;
            tail   <= '0;
            head   <= '0;
            phase  <= 1'b1;
            err    <= 1'b0;
        end else if (cfg_load) begin
            active <= 1'b1;
            last   <= cfg_last;
            tail   <= '0;
            head   <= '0;
            phase  <= 1'b1;
            err    <= 1'b0;
        end else begin
            if (push) begin
                tail <= nxt_tail;
                if (at_last) phase <= ~phase;
            end
            if (db_valid && active) begin
                if (db_head > last) err  <= 1'b1;
                else                head <= db_head;
            end
        end
    end
endmodule

// File: rtl/cqp_entry_pack.sv
module cqp_entry_pack
    import cqp_pkg::*;
(
    input  logic [31:0]           result,
    input  logic [14:0]           status,
    input  logic                  phase,
    input  logic [15:0]           sqid,
    input  logic [15:0]           sqhd,
    input  logic [15:0]           cid,
    output logic [ENTRY_BITS-1:0] data
);
    cq_entry_t ent;

    always_comb begin
        ent  = pack_entry(result, status, phase, sqid, sqhd, cid);
        data = ent;
    end
endmodule

// File: rtl/cqp_engine.sv
module cqp_engine
    import cqp_pkg::*;
#(
    parameter int SLOT_AW = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cfg_load,
    input  logic [SLOT_AW-1:0]    cfg_qsize,
    input  logic                  cfg_irq_en,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic [31:0]           req_result,
    input  logic [14:0]           req_status,
    input  logic [15:0]           req_sqid,
    input  logic [15:0]           req_sqhd,
    input  logic [15:0]           req_cid,
    input  logic                  db_valid,
    input  logic [SLOT_AW-1:0]    db_head,
    output logic                  ent_we,
    output logic [SLOT_AW-1:0]    ent_slot,
    output logic [ENTRY_BITS-1:0] ent_data,
    output logic                  ring_full,
    output logic                  ring_empty,
    output logic                  ring_phase,
    output logic [SLOT_AW-1:0]    ring_tail,
    output logic                  db_err,
    output logic                  irq_pulse
);
    logic               active;
    logic               push;
    logic               irq_en_q;
    logic [SLOT_AW-1:0] ring_last;
    logic [SLOT_AW-1:0] ring_head;

    assign req_ready = active && !ring_full && !cfg_load;
    assign push      = req_valid && req_ready;
    assign ent_we    = push;
    assign ent_slot  = ring_tail;

    cqp_ring_ptrs #(.AW(SLOT_AW)) u_ptrs (
        .clk      (clk),
        .rst      (rst),
        .cfg_load (cfg_load),
        .cfg_last (cfg_qsize),
        .push     (push),
        .db_valid (db_valid),
        .db_head  (db_head),
        .active   (active),
        .last     (ring_last),
        .tail     (ring_tail),
        .head     (ring_head),
        .phase    (ring_phase),
        .err      (db_err),
        .full     (ring_full),
        .empty    (ring_empty)
    );

    cqp_entry_pack u_pack (
        .result (req_result),
        .status (req_status),
        .phase  (ring_phase),
        .sqid   (req_sqid),
        .sqhd   (req_sqhd),
        .cid    (req_cid),
        .data   (ent_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_en_q  <= 1'b0;
            irq_pulse <= 1'b0;
        end else begin
            if (cfg_load) irq_en_q <= cfg_irq_en;
            irq_pulse <= push && irq_en_q;
        end
    end
endmodule

// File: rtl/cqp_engine_chk.sv
module cqp_engine_chk #(
    parameter int AW = 4
) (
    input logic          clk,
    input logic          rst,
    input logic          cfg_load,
    input logic          req_ready,
    input logic          ent_we,
    input logic [AW-1:0] ent_slot,
    input logic [127:0]  ent_data,
    input logic          ring_full,
    input logic          ring_phase,
    input logic [AW-1:0] ring_tail,
    input logic [AW-1:0] ring_last,
    input logic          irq_en_q,
    input logic          irq_pulse,
    input logic          db_err
);
    // R6
    full_blocks_ready_chk: assert property (@(posedge clk) disable iff (rst)
        ring_full |-> !req_ready);

    // R5
    phase_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (ent_we && (ent_slot == ring_last)) |=> (ring_phase != $past(ring_phase)));

    // R4
    tail_step_chk: assert property (@(posedge clk) disable iff (rst)
        (ent_we && (ent_slot != ring_last)) |=> (ring_tail == AW'($past(ent_slot) + 1'b1)));

    // R3
    entry_phase_chk: assert property (@(posedge clk) disable iff (rst)
        ent_we |-> (ent_data[112] == ring_phase));

    // R10
    irq_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (ent_we && irq_en_q) |=> irq_pulse);

    // R10
    irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !ent_we |=> !irq_pulse);

    // R9
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (db_err && !cfg_load) |=> db_err);
endmodule

bind cqp_engine cqp_engine_chk #(.AW(SLOT_AW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cfg_load   (cfg_load),
    .req_ready  (req_ready),
    .ent_we     (ent_we),
    .ent_slot   (ent_slot),
    .ent_data   (ent_data),
    .ring_full  (ring_full),
    .ring_phase (ring_phase),
    .ring_tail  (ring_tail),
    .ring_last  (ring_last),
    .irq_en_q   (irq_en_q),
    .irq_pulse  (irq_pulse),
    .db_err     (db_err)
);

// File: tb/cqp_engine_tb_top.sv
`timescale 1ns/1ps
module cqp_engine_tb_top;
    localparam int AW = 4;

    logic          clk = 1'b0;
    logic          rst;
    logic          cfg_load = 1'b0;
    logic [AW-1:0] cfg_qsize = '0;
    logic          cfg_irq_en = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [31:0]   req_result = '0;
    logic [14:0]   req_status = '0;
    logic [15:0]   req_sqid = '0;
    logic [15:0]   req_sqhd = '0;
    logic [15:0]   req_cid = '0;
    logic          db_valid = 1'b0;
    logic [AW-1:0] db_head = '0;
    logic          ent_we;
    logic [AW-1:0] ent_slot;
    logic [127:0]  ent_data;
    logic          ring_full, ring_empty, ring_phase, db_err, irq_pulse;
    logic [AW-1:0] ring_tail;

    int checks = 0;
    int fails  = 0;

    logic [AW-1:0] m_tail, m_last;
    logic          m_phase, m_irq;

    always #4 clk = ~clk;

    cqp_engine #(.SLOT_AW(AW)) dut_i (
        .clk(clk), .rst(rst), .cfg_load(cfg_load), .cfg_qsize(cfg_qsize),
        .cfg_irq_en(cfg_irq_en), .req_valid(req_valid), .req_ready(req_ready),
        .req_result(req_result), .req_status(req_status), .req_sqid(req_sqid),
        .req_sqhd(req_sqhd), .req_cid(req_cid), .db_valid(db_valid),
        .db_head(db_head), .ent_we(ent_we), .ent_slot(ent_slot),
        .ent_data(ent_data), .ring_full(ring_full), .ring_empty(ring_empty),
        .ring_phase(ring_phase), .ring_tail(ring_tail), .db_err(db_err),
        .irq_pulse(irq_pulse)
    );

    task automatic chk(input bit ok, input string tag,
                       input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (2) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk(req_ready == 0, "R1 ready", req_ready, 0);
        chk(ring_empty == 1, "R1 empty", ring_empty, 1);
        chk(ring_full == 0, "R1 full", ring_full, 0);
        chk(irq_pulse == 0 && db_err == 0, "R1 irq/err", {irq_pulse, db_err}, 0);
    endtask

    task automatic t_config(input logic [AW-1:0] qs, input logic ien);
        @(negedge clk);
        cfg_load = 1'b1; cfg_qsize = qs; cfg_irq_en = ien;
        @(posedge clk); #1 cfg_load = 1'b0;
        m_tail = '0; m_phase = 1'b1; m_last = qs; m_irq = ien;
        chk(ring_tail == 0 && ring_phase == 1, "R2 tail/phase", {ring_tail, ring_phase}, 1);
        chk(ring_empty == 1 && db_err == 0, "R2 empty/err", {ring_empty, db_err}, 2);
    endtask

    task automatic t_post(input logic [31:0] res, input logic [14:0] st,
                          input logic [15:0] sq, input logic [15:0] hd,
                          input logic [15:0] cid);
        logic [127:0] exp;
        @(negedge clk);
        req_valid = 1'b1; req_result = res; req_status = st;
        req_sqid = sq; req_sqhd = hd; req_cid = cid;
        #1;
        exp = {st, m_phase, cid, sq, hd, 32'h0, res};
        chk(req_ready == 1 && ent_we == 1, "R4 accept", {req_ready, ent_we}, 3);
        chk(ent_slot == m_tail, "R4 slot", ent_slot, m_tail);
        chk(ent_data == exp, "R3 layout", ent_data, exp);
        @(posedge clk); #1 req_valid = 1'b0;
        if (m_tail == m_last) begin m_tail = '0; m_phase = ~m_phase; end
        else m_tail = m_tail + 1'b1;
        chk(ring_tail == m_tail, "R4 tail step", ring_tail, m_tail);
        chk(ring_phase == m_phase, "R5 phase", ring_phase, m_phase);
        chk(irq_pulse == m_irq, "R10 strobe", irq_pulse, m_irq);
        @(posedge clk); #1;
        chk(irq_pulse == 0, "R10 single cycle", irq_pulse, 0);
    endtask

    task automatic t_door(input logic [AW-1:0] h);
        @(negedge clk);
        db_valid = 1'b1; db_head = h;
        @(posedge clk); #1 db_valid = 1'b0;
    endtask

    task automatic t_hold_when_full();
        chk(ring_full == 1, "R6 full flag", ring_full, 1);
        @(negedge clk);
        req_valid = 1'b1; #1;
        chk(req_ready == 0 && ent_we == 0, "R6 held off", {req_ready, ent_we}, 0);
        @(posedge clk); #1 req_valid = 1'b0;
        chk(ring_tail == m_tail, "R6 tail kept", ring_tail, m_tail);
    endtask

    task automatic t_wrap_and_doorbells();
        t_door(4'd2);
        chk(ring_full == 0, "R8 slots freed", ring_full, 0);
        t_post(32'h1111_0004, 15'h0, 16'd3, 16'd9, 16'h00D4);
        chk(ring_tail == 0 && ring_phase == 0, "R5 wrap", {ring_tail, ring_phase}, 0);
        t_post(32'h1111_0005, 15'h1F, 16'd3, 16'd10, 16'h00D5);
        chk(ring_full == 1, "R6 full after wrap", ring_full, 1);
        t_door(4'd9);
        chk(db_err == 1, "R9 error set", db_err, 1);
        chk(ring_full == 1, "R9 head unchanged", ring_full, 1);
        t_door(4'd1);
        chk(ring_empty == 1, "R7 empty", ring_empty, 1);
        chk(db_err == 1, "R9 sticky", db_err, 1);
    endtask

    task automatic t_small_ring_no_irq();
        t_config(4'd1, 1'b0);
        t_post(32'hCAFE_0001, 15'h2, 16'd1, 16'd1, 16'h0100);
        chk(ring_full == 1, "R6 two-slot full", ring_full, 1);
        t_door(4'd1);
        chk(ring_empty == 1, "R8 head moved", ring_empty, 1);
        t_post(32'hCAFE_0002, 15'h3, 16'd1, 16'd2, 16'h0101);
        chk(ring_phase == 0 && ring_tail == 0, "R5 small wrap", {ring_phase, ring_tail}, 0);
    endtask

    initial begin
        #(8 * 100000);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_config(4'd3, 1'b1);
        t_post(32'hA000_0001, 15'h0000, 16'd3, 16'd5, 16'h00A1);
        t_post(32'hA000_0002, 15'h7FFF, 16'hFFFF, 16'd6, 16'h00A2);
        t_post(32'h0, 15'h1234, 16'd3, 16'hFFFF, 16'hFFFF);
        t_hold_when_full();
        t_wrap_and_doorbells();
        t_small_ring_no_irq();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule